// File: doc/BRIEF.md
# Peripheral Clock Generator with Source Selection

This block makes one peripheral clock, such as an audio, serial-flash, pixel, card or USB-host clock, from one of two sources. The first source is the external reference, which passes to the output with no division. The second is a PLL-derived clock, which goes through a programmable divider that divides by the field value plus one. A gate input from the gating controller can stop the output. When stopped, the output rests low.

The design runs on a fast system clock `clk` and oversamples both source clocks. Each source must hold every level for at least one `clk` cycle. Every output transition comes from a register in the `clk` domain, so the output has no glitches.

The source-select FSM has three states:
- `SRC_REF`: the external reference drives the output.
- `SRC_PLL`: the divided PLL clock drives the output.
- `SRC_HANDOVER`: the output is held low while a source change completes.

The FSM has four transitions:
- `SRC_REF -> SRC_HANDOVER` when the PLL is requested and the gate stage is disabled.
- `SRC_PLL -> SRC_HANDOVER` when the reference is requested and the gate stage is disabled.
- `SRC_HANDOVER -> SRC_PLL` when both sources are low and the target is the PLL.
- `SRC_HANDOVER -> SRC_REF` when both sources are low and the target is the reference.

Top module: `pclk_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until a source edge arrives, `clk_o` is 0. Reset selects the external reference.
- R2: With the reference selected (`sel_pll_i`=0), `clk_o` has the same period and high time as `ref_clk_i`. The value on `div_i` has no effect.
- R3: With the PLL path selected, the output period is (`div_i`+1) PLL periods. A field of 0 passes the PLL clock through unchanged.
- R4: `div_i` is an unsigned DIV_W-bit value. Its all-ones value divides by 2^DIV_W.
- R5: A new `div_i` value is loaded only at an output rising edge, when the divide counter restarts.
- R6: While `gate_i`=1, `clk_o` makes no rising edge and rests at 0. The enable changes only while the selected clock is low, so no pulse is shortened. Clearing `gate_i` resumes the output.
- R7: A change of `sel_pll_i` while the output is enabled has no effect on the output.
- R8: A change of `sel_pll_i` while the output is gated takes effect only at a cycle when both sources are low. When `gate_i` clears, the output runs from the new source.
- R9: On the divided path with N = `div_i`+1 > 1, the output is high for ceil(N/2) PLL periods of every N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the sources |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | External reference clock level |
| pll_clk_i | input | 1 | PLL-derived clock level |
| sel_pll_i | input | 1 | 1 selects the divided PLL path, 0 selects the reference |
| div_i | input | DIV_W | Divide field; the divisor is the value plus one |
| gate_i | input | 1 | 1 stops the output |
| clk_o | output | 1 | Generated peripheral clock |

## Verification
The hardest case to reach from the ports is a source change. The mux accepts a new selection only after the gate stage has parked the output low. It then commits only in a cycle where both sampled sources are low.

The stimulus reaches this case in a fixed order:
1. It first flips the select while the output runs, and checks that the output waveform is unchanged.
2. It then raises the gate and waits for the handover to finish.
3. Finally it clears the gate and measures the period and high time of the new source.

It does this in both directions. It also moves the divide field between its extremes, waiting each time until the counter has wrapped.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    typedef enum logic [1:0] {
        SRC_REF      = 2'd0,
        SRC_PLL      = 2'd1,
        SRC_HANDOVER = 2'd2
    } src_state_e;
endpackage

// File: rtl/pclk_sync.sv
module pclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], d_i};
    end

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             div_o
);
    localparam int CW = DIV_W + 1;

    logic             src_d;
    logic             rise;
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;
    logic             hi_q;
    logic [CW-1:0]    half;
    logic [CW-1:0]    cnt_nx;
    logic             wrap;

    assign rise   = src_i & ~src_d;
    assign wrap   = (cnt_q >= lim_q);
    assign half   = ({1'b0, lim_q} + CW'(2)) >> 1;
    assign cnt_nx = {1'b0, cnt_q} + CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_d <= 1'b0;
            lim_q <= '0;
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            src_d <= src_i;
            if (rise) begin
                if (wrap) begin
                    cnt_q <= '0;
                    lim_q <= div_i;
                    hi_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_nx[DIV_W-1:0];
                    hi_q  <= (cnt_nx < half);
                end
            end
        end
    end

    assign div_o = (lim_q == '0) ? src_i : hi_q;

    // R3: the count never passes the active limit
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

    // R5: a new limit only appears together with a counter restart
    a_r5_limit_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lim_q) |-> (cnt_q == '0 && hi_q));
endmodule

// File: rtl/pclk_srcmux.sv
module pclk_srcmux
    import pclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_pll_i,
    input  logic en_i,
    input  logic ref_i,
    input  logic pll_i,
    output logic mux_o
);
    src_state_e state_q, state_n;
    logic       tgt_pll_q, tgt_pll_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SRC_REF;
            tgt_pll_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            tgt_pll_q <= tgt_pll_n;
        end
    end

    always_comb begin
        state_n   = state_q;
        tgt_pll_n = tgt_pll_q;
        unique case (state_q)
            SRC_REF: begin
                if (sel_pll_i && !en_i) begin
                    state_n   = SRC_HANDOVER;
                    tgt_pll_n = 1'b1;
                end
            end
            SRC_PLL: begin
                if (!sel_pll_i && !en_i) begin
                    state_n   = SRC_HANDOVER;
                    tgt_pll_n = 1'b0;
                end
            end
            SRC_HANDOVER: begin
                if (!ref_i && !pll_i)
                    state_n = tgt_pll_q ? SRC_PLL : SRC_REF;
            end
            default: state_n = SRC_REF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SRC_REF:      mux_o = ref_i;
            SRC_PLL:      mux_o = pll_i;
            SRC_HANDOVER: mux_o = 1'b0;
            default:      mux_o = 1'b0;
        endcase
    end

    // R7: a run state is left only while the gate stage is disabled
    a_r7_leave_only_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != SRC_HANDOVER && state_q == SRC_HANDOVER) |-> !$past(en_i));

    // R8: a handover commits only while both sources are low
    a_r8_commit_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == SRC_HANDOVER && state_q != SRC_HANDOVER)
            |-> (!$past(ref_i) && !$past(pll_i)));
endmodule

// File: rtl/pclk_gate.sv
module pclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic clk_i,
    output logic en_o,
    output logic clk_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (!clk_i) en_q <= !gate_i;
    end

    assign en_o  = en_q;
    assign clk_o = clk_i & en_q;

    // R6: the enable moves only while the selected clock is low
    a_r6_enable_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> !$past(clk_i));
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen #(
    parameter int DIV_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             pll_clk_i,
    input  logic             sel_pll_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             gate_i,
    output logic             clk_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] sampled;
    logic            pll_div;
    logic            mux_clk;
    logic            en;

    assign raw = {pll_clk_i, ref_clk_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        pclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw[g]),
            .q_o  (sampled[g])
        );
    end

    pclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .src_i(sampled[1]),
        .div_i(div_i),
        .div_o(pll_div)
    );

    pclk_srcmux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_pll_i(sel_pll_i),
        .en_i     (en),
        .ref_i    (sampled[0]),
        .pll_i    (pll_div),
        .mux_o    (mux_clk)
    );

    pclk_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .gate_i(gate_i),
        .clk_i (mux_clk),
        .en_o  (en),
        .clk_o (clk_o)
    );

    // R1: output is low while reset is applied
    a_r1_low_in_reset: assert property (@(posedge clk)
        !rst_n |=> !clk_o);
endmodule

// File: tb/pclk_gen_tb.sv
module pclk_gen_tb_top;
    localparam int DIV_W  = 9;
    localparam int SETTLE = 1200;

    typedef struct {
        int    period;
        int    high;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_clk = 1'b0;
    logic             pll_clk = 1'b0;
    logic             sel_pll = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic             gate = 1'b0;
    logic             clk_o;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sbq[$];
    bit   mon_done = 1'b0;
    int   ref_cnt = 0;

    always #10 clk = ~clk;

    pclk_gen #(.DIV_W(DIV_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk_i(ref_clk),
        .pll_clk_i(pll_clk),
        .sel_pll_i(sel_pll),
        .div_i    (div),
        .gate_i   (gate),
        .clk_o    (clk_o)
    );

    // sources: PLL period 2 clk cycles, reference period 10 clk cycles
    always @(negedge clk) begin
        pll_clk <= ~pll_clk;
        if (ref_cnt == 4) begin
            ref_cnt <= 0;
            ref_clk <= ~ref_clk;
        end else begin
            ref_cnt <= ref_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input bit lvl, output int n);
        n = 0;
        while (clk_o !== lvl && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // monitor: pops expected waveforms and measures clk_o against them
    initial begin
        exp_t e;
        int   a, h, l, rises;
        bit   prev;
        forever begin
            wait (sbq.size() > 0);
            e = sbq[0];
            if (e.period == 0) begin
                rises = 0;
                prev  = clk_o;
                repeat (300) begin
                    @(negedge clk);
                    if (clk_o && !prev) rises++;
                    prev = clk_o;
                end
                chk(rises == 0, e.req, rises, 0);
                chk(clk_o == 1'b0, e.req, int'(clk_o), 0);
            end else begin
                wait_level(1'b0, a);
                wait_level(1'b1, a);
                wait_level(1'b0, h);
                wait_level(1'b1, l);
                chk(h + l == e.period, e.req, h + l, e.period);
                chk(h == e.high, e.req, h, e.high);
            end
            void'(sbq.pop_front());
            mon_done = 1'b1;
        end
    end

    // driver: pushes one expected waveform and waits for the monitor
    task automatic expect_wave(input int p, input int h, input string r);
        exp_t e;
        e.period = p;
        e.high   = h;
        e.req    = r;
        mon_done = 1'b0;
        sbq.push_back(e);
        wait (mon_done);
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(clk_o == 1'b0, "R1", int'(clk_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_o == 1'b0, "R1", int'(clk_o), 0);

        div = 9'd2;
        settle();
        expect_wave(10, 5, "R2");
        div = 9'd7;
        settle();
        expect_wave(10, 5, "R2");

        sel_pll = 1'b1;
        settle();
        expect_wave(10, 5, "R7");

        gate = 1'b1;
        settle();
        expect_wave(0, 0, "R6");

        div  = 9'd2;
        gate = 1'b0;
        settle();
        expect_wave(6, 4, "R8");

        div = 9'd0;
        settle();
        expect_wave(2, 1, "R3");

        div = 9'd5;
        settle();
        expect_wave(12, 6, "R9");

        div = 9'd511;
        settle();
        expect_wave(1024, 512, "R4");

        div = 9'd3;
        settle();
        expect_wave(8, 4, "R5");

        gate = 1'b1;
        settle();
        expect_wave(0, 0, "R6");
        sel_pll = 1'b0;
        settle();
        gate = 1'b0;
        settle();
        expect_wave(10, 5, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule